// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Pairs

The block watches write-class requests as they complete at a cache and keeps a reservation for each requester. A load-linked completion sets the requester's reservation on its line. A later store-conditional from the same requester succeeds only while that reservation still stands. Every write-class completion gets a registered one-bit success flag and a zero-extended return value, one cycle after it completes. The pipeline returns that value to the processor.

The reservation table is also cleared by other traffic. Every store-conditional clears the reservation on its line. A plain write by the owner clears it when the line is present. Cache invalidations and evictions clear it too. The same block maps each incoming request type to the class it is issued under downstream. It also pulses block and unblock controls for locked read-modify-write pairs. A test-mode input bypasses the reservation logic and reports every write as successful.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked completion (kind 6) reports success. It sets the requester's reservation to its line, replacing any earlier one held by that requester. It also removes the same line from any other requester.
- R2: A store-conditional (kind 7) reports success only if its requester holds a valid reservation on exactly that line. `rsp_value` is 1 on success and 0 on failure. Every write-class completion (all kinds except 0 load and 1 fetch) raises `rsp_valid` for exactly the cycle after it completes.
- R3: Every store-conditional clears any reservation on its line, whether it succeeds or fails.
- R4: A plain write-class completion by the owner of the line's reservation clears that reservation when `cmp_present` is 1. Such writes are kinds 2 store, 3 atomic, 4 rmw-read, 5 rmw-write, 8 locked-read, 9 locked-write and 10 flush. The same write leaves the reservation in place when `cmp_present` is 0, and a write by another requester leaves it in place.
- R5: An `inv_valid` pulse clears every reservation whose line equals `inv_line`. It takes effect before a store-conditional that completes in the same cycle.
- R6: Load and fetch completions produce no response and leave all reservations unchanged.
- R7: `iss_class` is driven from `iss_kind` in the same cycle: fetch→0, load→1, store/rmw/locked→2, LL/SC/atomic→3, flush→4.
- R8: A locked-read completion pulses `lock_blk` in the next cycle, with `lock_line` set to its line. A locked-write completion pulses `lock_unblk` the same way. The two never pulse together.
- R9: While `test_mode` is 1, every write-class completion reports success and the reservation table is not changed.
- R10: After reset no reservation is held and `rsp_valid`, `lock_blk` and `lock_unblk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Bypass reservation logic, report success |
| cmp_valid | input | 1 | A request completes this cycle |
| cmp_kind | input | 4 | Kind of the completing request |
| cmp_line | input | LINE_W | Line address of the completing request |
| cmp_req | input | ID_W | Requester ID of the completing request |
| cmp_present | input | 1 | Line tag is present in the cache |
| inv_valid | input | 1 | Invalidate/eviction notification |
| inv_line | input | LINE_W | Line being invalidated or evicted |
| iss_kind | input | 4 | Kind of a request about to be issued |
| iss_class | output | 3 | Downstream class for `iss_kind` |
| rsp_valid | output | 1 | Write-class result valid |
| rsp_ok | output | 1 | Success flag |
| rsp_value | output | VAL_W | Value returned to the processor |
| lock_blk | output | 1 | Block queued requests to `lock_line` |
| lock_unblk | output | 1 | Unblock `lock_line` |
| lock_line | output | LINE_W | Line for the block/unblock controls |

## Verification
The bench builds the block with four requesters, an 8-bit line address and an 8-bit return value. The small line width makes it easy to place two requesters on the same line and to make a line match or miss on purpose. Four requesters are enough to show that one requester's load-linked steals a line from another, and that writes by non-owners leave reservations alone. The bench also covers an invalidation arriving in the same cycle as a store-conditional.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NUM_REQ = 4,
  parameter int LINE_W  = 26,
  parameter int VAL_W   = 64,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              cmp_valid,
  input  logic [3:0]        cmp_kind,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic [ID_W-1:0]   cmp_req,
  input  logic              cmp_present,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic [3:0]        iss_kind,
  output logic [2:0]        iss_class,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [VAL_W-1:0]  rsp_value,
  output logic              lock_blk,
  output logic              lock_unblk,
  output logic [LINE_W-1:0] lock_line
);
  localparam logic [3:0] K_LOAD = 4'd0, K_FETCH = 4'd1, K_STORE = 4'd2,
                         K_ATOM = 4'd3, K_RMWR = 4'd4, K_RMWW = 4'd5,
                         K_LL = 4'd6, K_SC = 4'd7, K_LKRD = 4'd8,
                         K_LKWR = 4'd9, K_FLUSH = 4'd10;

  logic [NUM_REQ-1:0]             rv_q, rv_inv, rv_d, line_eq, is_me;
  logic [NUM_REQ-1:0][LINE_W-1:0] rl_q, rl_d;

  wire is_wr   = cmp_valid && cmp_kind != K_LOAD && cmp_kind != K_FETCH;
  wire upd     = is_wr && !test_mode;
  wire own_hit = |(rv_inv & line_eq & is_me);
  wire ok      = test_mode || cmp_kind != K_SC || own_hit;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_ent
    assign line_eq[i] = rl_q[i] == cmp_line;
    assign is_me[i]   = cmp_req == ID_W'(i);
    assign rv_inv[i]  = rv_q[i] && !(inv_valid && rl_q[i] == inv_line);

    always_comb begin
      rv_d[i] = rv_inv[i];
      rl_d[i] = rl_q[i];
      if (upd) begin
        if (cmp_kind == K_LL) begin
          if (is_me[i]) begin
            rv_d[i] = 1'b1;
            rl_d[i] = cmp_line;
          end else if (line_eq[i]) begin
            rv_d[i] = 1'b0;
          end
        end else if (cmp_kind == K_SC) begin
          if (line_eq[i]) rv_d[i] = 1'b0;
        end else if (is_me[i] && line_eq[i] && cmp_present) begin
          rv_d[i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q       <= '0;
      rl_q       <= '0;
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      lock_blk   <= 1'b0;
      lock_unblk <= 1'b0;
      lock_line  <= '0;
    end else begin
      rv_q       <= rv_d;
      rl_q       <= rl_d;
      rsp_valid  <= is_wr;
      rsp_ok     <= is_wr && ok;
      lock_blk   <= cmp_valid && cmp_kind == K_LKRD;
      lock_unblk <= cmp_valid && cmp_kind == K_LKWR;
      if (cmp_valid && (cmp_kind == K_LKRD || cmp_kind == K_LKWR))
        lock_line <= cmp_line;
    end
  end

  assign rsp_value = VAL_W'(rsp_ok);

  always_comb begin
    unique case (iss_kind)
      K_FETCH:                                   iss_class = 3'd0;
      K_LOAD:                                    iss_class = 3'd1;
      K_STORE, K_RMWR, K_RMWW, K_LKRD, K_LKWR:   iss_class = 3'd2;
      K_LL, K_SC, K_ATOM:                        iss_class = 3'd3;
      K_FLUSH:                                   iss_class = 3'd4;
      default:                                   iss_class = 3'd7;
    endcase
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_mode,
  input logic              cmp_valid,
  input logic [3:0]        cmp_kind,
  input logic [LINE_W-1:0] cmp_line,
  input logic [ID_W-1:0]   cmp_req,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              lock_blk,
  input logic              lock_unblk,
  input logic [LINE_W-1:0] lock_line
);
  assert_ll_succeeds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == 4'd6 |=> rsp_valid && rsp_ok);

  assert_sc_after_sc_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == 4'd7 && !test_mode &&
    $past(cmp_valid && cmp_kind == 4'd7 && !test_mode) &&
    $past(cmp_line) == cmp_line |=> !rsp_ok);

  assert_read_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind <= 4'd1 |=> !rsp_valid);

  assert_lock_blk_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_kind == 4'd8 |=> lock_blk && lock_line == $past(cmp_line));

  assert_lock_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_blk && lock_unblk));

  assert_test_mode_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && test_mode && cmp_kind > 4'd1 |=> rsp_ok);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .cmp_valid(cmp_valid),
  .cmp_kind(cmp_kind), .cmp_line(cmp_line), .cmp_req(cmp_req),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .lock_blk(lock_blk),
  .lock_unblk(lock_unblk), .lock_line(lock_line));

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
  localparam int NR = 4, LW = 8, VW = 8, IW = 2;

  logic clk = 0, rst_n = 0, test_mode = 0, cmp_valid = 0, cmp_present = 0, inv_valid = 0;
  logic [3:0] cmp_kind = 0, iss_kind = 0;
  logic [LW-1:0] cmp_line = 0, inv_line = 0, lock_line;
  logic [IW-1:0] cmp_req = 0;
  logic [2:0] iss_class;
  logic rsp_valid, rsp_ok, lock_blk, lock_unblk;
  logic [VW-1:0] rsp_value;

  always #2.5 clk = ~clk;

  llsc_monitor #(.NUM_REQ(NR), .LINE_W(LW), .VAL_W(VW)) dut_i (.*);

  typedef struct {
    logic vld; logic ok; logic blk; logic unblk; logic [LW-1:0] line; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic drv_flag = 0;
  logic          bm_v[NR];
  logic [LW-1:0] bm_l[NR];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, logic [3:0] k, logic [LW-1:0] ln, int rq,
                    logic pres = 1, logic iv = 0, logic [LW-1:0] il = 0, logic tm = 0);
    exp_t e;
    logic wr, hit, ok;
    @(posedge clk); #1;
    cmp_valid = 1; cmp_kind = k; cmp_line = ln; cmp_req = IW'(rq);
    cmp_present = pres; inv_valid = iv; inv_line = il; test_mode = tm;
    drv_flag = 1;
    for (int i = 0; i < NR; i++)
      if (iv && bm_v[i] && bm_l[i] == il) bm_v[i] = 0;
    wr  = k > 4'd1;
    hit = bm_v[rq] && bm_l[rq] == ln;
    ok  = tm || k != 4'd7 || hit;
    if (wr && !tm) begin
      if (k == 4'd6) begin
        for (int i = 0; i < NR; i++) if (i != rq && bm_v[i] && bm_l[i] == ln) bm_v[i] = 0;
        bm_v[rq] = 1; bm_l[rq] = ln;
      end else if (k == 4'd7) begin
        for (int i = 0; i < NR; i++) if (bm_l[i] == ln) bm_v[i] = 0;
      end else if (pres && hit) bm_v[rq] = 0;
    end
    e.vld = wr; e.ok = wr && ok; e.blk = (k == 4'd8); e.unblk = (k == 4'd9);
    e.line = ln; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    cmp_valid = 0; inv_valid = 0; test_mode = 0; drv_flag = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (drv_flag) begin
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        check({e.tag, " vld"}, rsp_valid, e.vld);
        check({e.tag, " ok"},  rsp_ok, e.ok);
        check({e.tag, " val"}, rsp_value, {7'b0, e.ok});
        check({e.tag, " blk"}, lock_blk, e.blk);
        check({e.tag, " unblk"}, lock_unblk, e.unblk);
        if (e.blk || e.unblk) check({e.tag, " line"}, lock_line, e.line);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin bm_v[i] = 0; bm_l[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R10 reset rsp_valid", rsp_valid, 0);
    check("R10 reset lock", {lock_blk, lock_unblk}, 0);
    op("R10 sc after reset fails", 4'd7, 8'h00, 0);
    // R1 / R2
    op("R1 ll", 4'd6, 8'h10, 0);
    op("R2 sc owner ok", 4'd7, 8'h10, 0);
    op("R3 sc again fails", 4'd7, 8'h10, 0);
    op("R1 ll a", 4'd6, 8'h20, 1);
    op("R1 ll replace", 4'd6, 8'h21, 1);
    op("R1 old line gone", 4'd7, 8'h20, 1);
    op("R1 ll x", 4'd6, 8'h30, 2);
    op("R1 ll steal", 4'd6, 8'h30, 3);
    op("R1 stolen sc fails", 4'd7, 8'h30, 2);
    op("R2 thief sc ok", 4'd7, 8'h30, 3);
    // R3: failed SC by other requester clears owner
    op("R3 ll", 4'd6, 8'h40, 0);
    op("R3 foreign sc fails", 4'd7, 8'h40, 1);
    op("R3 owner sc after clear", 4'd7, 8'h40, 0);
    // R4
    op("R4 ll", 4'd6, 8'h50, 1);
    op("R4 store not present", 4'd2, 8'h50, 1, 0);
    op("R4 store other req", 4'd2, 8'h50, 2, 1);
    op("R4 sc survives", 4'd7, 8'h50, 1);
    op("R4 ll", 4'd6, 8'h51, 1);
    op("R4 owner store", 4'd2, 8'h51, 1, 1);
    op("R4 sc after store fails", 4'd7, 8'h51, 1);
    op("R4 ll", 4'd6, 8'h52, 2);
    op("R4 owner flush", 4'd10, 8'h52, 2, 1);
    op("R4 sc after flush fails", 4'd7, 8'h52, 2);
    // R5
    op("R5 ll", 4'd6, 8'h60, 0);
    op("R5 load with inv", 4'd0, 8'h00, 1, 1, 1, 8'h60);
    op("R5 sc after inv fails", 4'd7, 8'h60, 0);
    op("R5 ll", 4'd6, 8'h61, 0);
    op("R5 inv other line", 4'd0, 8'h00, 1, 1, 1, 8'h62);
    op("R5 sc ok", 4'd7, 8'h61, 0);
    op("R5 ll", 4'd6, 8'h63, 0);
    op("R5 same cycle inv + sc", 4'd7, 8'h63, 0, 1, 1, 8'h63);
    // R6
    op("R6 ll", 4'd6, 8'h70, 3);
    op("R6 load", 4'd0, 8'h70, 3);
    op("R6 fetch", 4'd1, 8'h70, 3);
    op("R6 sc ok", 4'd7, 8'h70, 3);
    // R8
    op("R8 locked read", 4'd8, 8'hA5, 0);
    op("R8 locked write", 4'd9, 8'h5A, 0);
    // R9
    op("R9 tm sc", 4'd7, 8'h80, 2, 1, 0, 0, 1);
    op("R9 ll", 4'd6, 8'h81, 2);
    op("R9 tm sc same line", 4'd7, 8'h81, 2, 1, 0, 0, 1);
    op("R9 tm ll other", 4'd6, 8'h81, 3, 1, 0, 0, 1);
    op("R9 sc untouched", 4'd7, 8'h81, 2);
    // R7
    for (int k = 0; k <= 10; k++) begin
      logic [2:0] ec;
      ec = (k == 1) ? 3'd0 : (k == 0) ? 3'd1 : (k == 10) ? 3'd4 :
           (k == 3 || k == 6 || k == 7) ? 3'd3 : 3'd2;
      iss_kind = 4'(k);
      #1 check($sformatf("R7 class kind %0d", k), iss_class, ec);
    end
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule